// File: doc/BRIEF.md
# Burst-Mode Oversampled Phase Aligner

This block recovers the bits of short upstream bursts that arrive at the local bit rate but with an unknown phase. On every bit-period clock it receives one word of `NPH` samples of the serial line. Sample index k was taken at phase k of the local clock, and index 0 is the earliest. A one-cycle `burst_rst` pulse starts a new acquisition. The block first clears itself for a fixed number of cycles. It then watches an alternating 1/0 preamble for a fixed number of bit periods and counts, at each phase boundary, how often the line changed there. It then samples every later word at the phase half a bit away from the busiest boundary.

There is no tracking loop. The chosen phase stays fixed until the next burst reset, and lock is reached at a fixed cycle count after the reset. The recovered stream leaves with a valid strobe and no ready input. A serial line cannot be stalled, so the block applies no back-pressure: while locked it delivers one bit on every clock, and a consumer that cannot take it loses it. `sel_phase` shows the phase chosen for the current burst.

Top module: `burst_phase_aligner`

## Requirements
- R1: A `burst_rst` sampled high at any clock edge, locked or not, clears `lock`, `out_valid` and `out_data` after that edge, returns `sel_phase` to 0 and restarts the sequence from its first cycle.
- R2: The five clock edges after the reset edge only initialise. The words sampled at edges 6 to 13 after the reset edge form the measurement window. The position-0 comparison of the first window word uses the last sample of the word from edge 5. Words from edges 1 to 4 have no effect on the outcome.
- R3: A change between adjacent samples is a transition. Position 0 compares sample NPH-1 of the previous word with sample 0 of the current word, and position k>0 compares samples k-1 and k of the current word. If the window holds a total number of transitions other than 8, the burst never locks, until the next `burst_rst`.
- R4: The transition position is the position with the most transitions counted over the window. When counts are equal, the lowest position index wins.
- R5: From the 14th edge after the reset edge, `sel_phase` equals (transition position + 4) mod 8. It holds that value until the next `burst_rst` and is 0 before that edge.
- R6: With a valid window, `lock` rises after exactly the 17th edge after the reset edge and stays high until a burst reset or a global reset.
- R7: While locked, `out_data` after edge n is sample `sel_phase` of the word sampled at edge n-2. The first valid bit comes from the word of the 15th edge.
- R8: `out_valid` equals `lock`, and it is high on every cycle while locked. While unlocked, `out_data` is 0.
- R9: `rst_n` low clears `lock`, `out_valid`, `out_data` and `sel_phase` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| burst_rst | input | 1 | One-cycle pulse that starts acquisition of a new burst |
| samp_in | input | NPH | Line samples of one bit period, index 0 earliest |
| out_data | output | 1 | Retimed bit, 0 while unlocked |
| out_valid | output | 1 | Qualifies `out_data`; no ready, no back-pressure |
| lock | output | 1 | Burst acquired, output stream is valid |
| sel_phase | output | $clog2(NPH) | Sample phase chosen for the current burst |

## Verification
The hardest state to reach from the ports is a tie between two phase counts, because a clean preamble puts every transition on a single boundary. The stimulus widens every 1 bit of the preamble by a chosen number of samples. With a widening of half a bit, rising and falling edges land on two boundaries with equal counts, and the bench checks that the lower index wins in both orders. Two further cases are driven on purpose: a burst reset late enough that the window runs into a flat payload, which must never lock, and a second burst reset that arrives while the block is already locked.

// File: rtl/pa_pkg.sv
package pa_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // Acquisition sequence of one burst
  typedef enum logic [2:0] {
    ST_IDLE,   // nothing acquired since global reset
    ST_INIT,   // internal clearing period
    ST_MEAS,   // counting transitions over the preamble window
    ST_ALIGN,  // load the chosen phase
    ST_FILL,   // prime the output pipeline
    ST_LOCK,   // streaming retimed bits
    ST_FAIL    // window did not look like a preamble
  } pa_state_e;
endpackage

// File: rtl/pa_edge_tally.sv
module pa_edge_tally #(
  parameter int NPH       = 8,
  parameter int MEAS_BITS = 8,
  parameter int CW        = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic [NPH-1:0]          samp,
  output logic [NPH-1:0][CW-1:0]  tally,
  output logic                    meas_ok
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int TW = $clog2(NPH * MEAS_BITS + 1);

  logic           last_q;
  logic [NPH-1:0] edge_v;
  logic [TW-1:0]  tot_q;

  // last sample of the previous word, for the wrap-around boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= samp[NPH-1];
  end

  generate
    for (genvar k = 0; k < NPH; k++) begin : g_pos
      logic [CW-1:0] cnt_q;
      if (k == 0) begin : g_wrap
        assign edge_v[k] = samp[0] ^ last_q;
      end else begin : g_inner
        assign edge_v[k] = samp[k] ^ samp[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     cnt_q <= '0;
        else if (clr)                                   cnt_q <= '0;
        else if (en && edge_v[k] && (cnt_q != CW'(MEAS_BITS))) cnt_q <= cnt_q + 1'b1;
      end
      assign tally[k] = cnt_q;
    end
  endgenerate

  // total transitions over the window qualifies the preamble
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tot_q <= '0;
    else if (clr) tot_q <= '0;
    else if (en)  tot_q <= tot_q + TW'($countones(edge_v));
  end

  assign meas_ok = (tot_q == TW'(MEAS_BITS));

  AST_TALLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(tot_q)) else $error("tally moved outside window"); // R2

endmodule

// File: rtl/pa_phase_pick.sv
module pa_phase_pick #(
  parameter int NPH = 8,
  parameter int CW  = 4,
  parameter int PW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPH-1:0][CW-1:0]  tally,
  output logic [PW-1:0]           centre
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [PW-1:0] edge_pos;

  // strict compare keeps the lowest index among equal counts
  always_comb begin
    edge_pos = '0;
    for (int k = 1; k < NPH; k++) begin
      if (tally[k] > tally[edge_pos]) edge_pos = PW'(k);
    end
  end

  assign centre = PW'((int'(edge_pos) + NPH / 2) % NPH);

  generate
    for (genvar k = 0; k < NPH; k++) begin : g_chk
      AST_PICK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        tally[k] <= tally[edge_pos]) else $error("picked position not maximal"); // R4
      AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(k) < edge_pos) |-> (tally[k] < tally[edge_pos])) else $error("tie not broken low"); // R4
    end
  endgenerate

endmodule

// File: rtl/pa_burst_seq.sv
module pa_burst_seq
  import pa_pkg::*;
#(
  parameter int INIT_CYC   = 5,
  parameter int MEAS_BITS  = 8,
  parameter int PIPE_DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_rst,
  input  logic meas_ok,
  output logic tally_clr,
  output logic meas_en,
  output logic sel_load,
  output logic shift_en,
  output logic lock
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNTW = $clog2(INIT_CYC + MEAS_BITS + PIPE_DEPTH + 1);

  pa_state_e       st;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      lock <= 1'b0;
    end else if (burst_rst) begin
      st   <= ST_INIT;
      cnt  <= '0;
      lock <= 1'b0;
    end else begin
      unique case (st)
        ST_INIT: begin
          if (cnt == CNTW'(INIT_CYC - 1)) begin
            st  <= ST_MEAS;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_MEAS: begin
          if (cnt == CNTW'(MEAS_BITS - 1)) begin
            st  <= ST_ALIGN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ALIGN: begin
          st  <= meas_ok ? ST_FILL : ST_FAIL;
          cnt <= '0;
        end
        ST_FILL: begin
          if (cnt == CNTW'(PIPE_DEPTH - 1)) begin
            st   <= ST_LOCK;
            lock <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign tally_clr = burst_rst;
  assign meas_en   = (st == ST_MEAS) && !burst_rst;
  assign sel_load  = (st == ST_ALIGN) && !burst_rst;
  assign shift_en  = (st == ST_FILL) || (st == ST_LOCK);

  AST_RST_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    burst_rst |=> !lock) else $error("lock survived burst reset"); // R1
  AST_LOCK_NEEDS_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> meas_ok) else $error("locked on bad window"); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !burst_rst) |=> lock) else $error("lock dropped"); // R6

endmodule

// File: rtl/pa_retime.sv
module pa_retime #(
  parameter int NPH        = 8,
  parameter int PW         = 3,
  parameter int PIPE_DEPTH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           sel_load,
  input  logic [PW-1:0]  sel_in,
  input  logic           shift_en,
  input  logic           lock,
  input  logic [NPH-1:0] samp,
  output logic [PW-1:0]  sel_q,
  output logic           out_data,
  output logic           out_valid
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [PIPE_DEPTH-1:0] pipe_q;
  logic [PIPE_DEPTH-1:0] pipe_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= '0;
    else if (clr)      sel_q <= '0;
    else if (sel_load) sel_q <= sel_in;
  end

  generate
    if (PIPE_DEPTH == 1) begin : g_single
      assign pipe_nxt = samp[sel_q];
    end else begin : g_chain
      assign pipe_nxt = {pipe_q[PIPE_DEPTH-2:0], samp[sel_q]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pipe_q <= '0;
    else if (clr)      pipe_q <= '0;
    else if (shift_en) pipe_q <= pipe_nxt;
  end

  assign out_data  = lock & pipe_q[PIPE_DEPTH-1];
  assign out_valid = lock;

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |-> $stable(sel_q)) else $error("phase moved while locked"); // R5
  AST_PIPE_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(shift_en)) else $error("lock before pipeline fill"); // R7

endmodule

// File: rtl/burst_phase_aligner.sv
module burst_phase_aligner #(
  parameter int NPH        = 8,
  parameter int INIT_CYC   = 5,
  parameter int MEAS_BITS  = 8,
  parameter int PIPE_DEPTH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   burst_rst,
  input  logic [NPH-1:0]         samp_in,
  output logic                   out_data,
  output logic                   out_valid,
  output logic                   lock,
  output logic [$clog2(NPH)-1:0] sel_phase
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PW = $clog2(NPH);
  localparam int CW = $clog2(MEAS_BITS + 1);

  logic [NPH-1:0][CW-1:0] tally;
  logic                   meas_ok;
  logic                   tally_clr;
  logic                   meas_en;
  logic                   sel_load;
  logic                   shift_en;
  logic [PW-1:0]          centre;

  pa_burst_seq #(
    .INIT_CYC  (INIT_CYC),
    .MEAS_BITS (MEAS_BITS),
    .PIPE_DEPTH(PIPE_DEPTH)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .burst_rst(burst_rst),
    .meas_ok  (meas_ok),
    .tally_clr(tally_clr),
    .meas_en  (meas_en),
    .sel_load (sel_load),
    .shift_en (shift_en),
    .lock     (lock)
  );

  pa_edge_tally #(
    .NPH      (NPH),
    .MEAS_BITS(MEAS_BITS),
    .CW       (CW)
  ) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tally_clr),
    .en     (meas_en),
    .samp   (samp_in),
    .tally  (tally),
    .meas_ok(meas_ok)
  );

  pa_phase_pick #(
    .NPH(NPH),
    .CW (CW),
    .PW (PW)
  ) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .tally (tally),
    .centre(centre)
  );

  pa_retime #(
    .NPH       (NPH),
    .PW        (PW),
    .PIPE_DEPTH(PIPE_DEPTH)
  ) u_retime (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (burst_rst),
    .sel_load (sel_load),
    .sel_in   (centre),
    .shift_en (shift_en),
    .lock     (lock),
    .samp     (samp_in),
    .sel_q    (sel_phase),
    .out_data (out_data),
    .out_valid(out_valid)
  );

  AST_VALID_TRACKS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == lock) else $error("valid and lock disagree"); // R8

endmodule

// File: tb/burst_phase_aligner_bench.sv
module burst_phase_aligner_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_rst = 1'b0;
  logic [7:0] samp_in = '0;
  logic       out_data, out_valid, lock;
  logic [2:0] sel_phase;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_phase_aligner u_burst_phase_aligner (
    .clk(clk), .rst_n(rst_n), .burst_rst(burst_rst), .samp_in(samp_in),
    .out_data(out_data), .out_valid(out_valid), .lock(lock), .sel_phase(sel_phase)
  );

  // reference model state
  int         e = 100000;
  bit         ok = 0;
  bit         started = 0;
  int         mcnt[8];
  int         mtot = 0;
  int         msel = 0;
  logic [7:0] prevw = '0, h0 = '0, h1 = '0, h2 = '0;

  // stimulus state
  int ph_b = 0, wid_b = 0;
  bit bstr[256];

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    e = 100000; ok = 0; started = 0; msel = 0; mtot = 0;
    prevw = '0; h0 = '0; h1 = '0; h2 = '0;
  endtask

  task automatic model_step(logic [7:0] w, bit r);
    if (r) begin
      e = 0; ok = 0; started = 1; msel = 0; mtot = 0;
      for (int k = 0; k < 8; k++) mcnt[k] = 0;
    end else if (e < 100000) e++;
    if (!r && started && e >= 6 && e <= 13) begin
      for (int k = 0; k < 8; k++) begin
        bit ed = (k == 0) ? (prevw[7] ^ w[0]) : (w[k] ^ w[k-1]);
        if (ed) begin mcnt[k]++; mtot++; end
      end
    end
    if (!r && started && e == 14) begin
      int best = 0;
      for (int k = 1; k < 8; k++) if (mcnt[k] > mcnt[best]) best = k;
      msel = (best + 4) % 8;
      ok = (mtot == 8);
    end
    h2 = h1; h1 = h0; h0 = w; prevw = w;
  endtask

  task automatic check_cycle(string tag);
    bit elock = started && ok && (e >= 17);
    int edata = elock ? int'(h2[msel]) : 0;
    int esel = (started && e >= 14) ? msel : 0;
    chk({"R6 ", tag}, int'(lock), int'(elock), "lock");
    chk("R8", int'(out_valid), int'(elock), "out_valid");
    chk(elock ? "R7" : "R8", int'(out_data), edata, "out_data");
    chk({"R5 ", tag}, int'(sel_phase), esel, "sel_phase");
  endtask

  function automatic logic [7:0] mkword(int c);
    logic [7:0] w = '0;
    for (int i = 0; i < 8; i++) begin
      int p = 8 * c + i - ph_b;
      bit v = 0;
      if (p >= 0) begin
        v = bstr[(p >> 3) & 255];
        if (wid_b > 0 && p - wid_b >= 0) v = v | bstr[((p - wid_b) >> 3) & 255];
      end
      w[i] = v;
    end
    return w;
  endfunction

  // one burst: alternating preamble from bit 0, eight flat 0 bits, then random payload
  task automatic run_burst(int ph, int wid, int r, int r2, int pre, int len, bit junk, string tag);
    ph_b = ph; wid_b = wid;
    for (int k = 0; k < 256; k++)
      bstr[k] = (k < pre) ? (k % 2 == 0) : ((k < pre + 8) ? 1'b0 : 1'($urandom % 2));
    for (int c = 0; c < len; c++) begin
      logic [7:0] w = (junk && c > r && c <= r + 4) ? 8'($urandom) : mkword(c);
      samp_in = w;
      burst_rst = (c == r) || (c == r2);
      @(posedge clk);
      model_step(w, burst_rst);
      @(negedge clk);
      check_cycle(tag);
    end
    burst_rst = 1'b0;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd7321);
    model_clear();
    repeat (3) @(negedge clk);
    chk("R9", int'(lock), 0, "lock in reset");
    chk("R9", int'(out_valid), 0, "out_valid in reset");
    chk("R9", int'(sel_phase), 0, "sel_phase in reset");
    rst_n = 1'b1;
    @(negedge clk);

    run_burst(3, 0, 4, -1, 32, 40, 0, "basic");
    run_burst(0, 0, 2, -1, 32, 40, 0, "wrap boundary");
    run_burst(7, 0, 10, -1, 32, 40, 0, "last phase");
    run_burst(2, 4, 5, -1, 32, 40, 0, "R4 tie rising low");
    run_burst(6, 4, 5, -1, 32, 40, 0, "R4 tie falling low");
    run_burst(5, 2, 3, -1, 32, 40, 0, "distorted");
    run_burst(1, 0, 24, -1, 32, 60, 0, "R3 late reset");
    run_burst(4, 0, 3, -1, 32, 40, 1, "R2 junk during init");
    run_burst(6, 0, 2, 9, 32, 40, 0, "R1 reset in window");
    run_burst(2, 1, 2, 25, 48, 60, 0, "R1 reset while locked");

    // global reset while locked
    run_burst(5, 0, 3, -1, 32, 30, 0, "before global reset");
    rst_n = 1'b0;
    #0.5;
    chk("R9", int'(lock), 0, "lock after async reset");
    chk("R9", int'(out_valid), 0, "out_valid after async reset");
    chk("R9", int'(out_data), 0, "out_data after async reset");
    chk("R9", int'(sel_phase), 0, "sel_phase after async reset");
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    run_burst(1, 0, 6, -1, 32, 40, 0, "after global reset");

    for (int b = 0; b < 24; b++)
      run_burst(int'($urandom % 8), int'($urandom % 4), int'($urandom % 15), -1, 32,
                40 + int'($urandom % 20), 1'($urandom % 2), "random");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule